// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block chooses which physical frame to evict when a new page must be brought in. For every frame it holds a reference bit and a dirty bit. Memory accesses set the reference bit of the frame they touch, and stores also set its dirty bit. A pointer marks the frame most recently chosen.

When a selection is requested, the engine sweeps the frames one per clock cycle. It starts just after the pointer and wraps around at the end of the table. Any recently used frame that the sweep passes loses its reference bit. The first frame that has not been used recently becomes the victim. An optional clean-preferred mode instead looks for a frame that is both unused and unmodified, so that no write-back is needed. If that search finds nothing within two full turns, the engine falls back to an unused dirty frame.

When the replacement page has been loaded into the victim frame, the surrounding logic pulses a reload input, which clears that frame's bits.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all reference and dirty bits are 0, `busy` and `done` are low, and the pointer sits on the last frame, so the first sweep starts at frame 0.
- R2: `acc_valid` sets the reference bit of `acc_frame`. When `acc_store` is also high, the dirty bit of that frame is set as well.
- R3: `reload_valid` clears both the reference bit and the dirty bit of `reload_frame`.
- R4: In normal mode (`prefer_clean`=0 when `req` is accepted), the sweep examines one frame per cycle, starting at pointer+1 modulo NFRAMES. The victim is the first examined frame whose reference bit is 0. `done` is a one-cycle pulse that rises k cycles after the accepting edge, where k is the number of frames examined.
- R5: Every examined frame whose reference bit is 1 has that bit cleared by the sweep.
- R6: In clean-preferred mode (`prefer_clean`=1 when `req` is accepted), the victim is the first examined frame whose reference bit and dirty bit are both 0.
- R7: In clean-preferred mode, if no such frame is found within 2*NFRAMES examinations, the victim is the first frame seen with its reference bit at 0. If there was none, the victim is the last frame examined.
- R8: `victim_dirty` gives the dirty bit that the victim frame held when it was chosen. It is valid while `done` is high.
- R9: The pointer stays on the chosen victim, so the next sweep starts at the frame after it.
- R10: When an access hits the frame that the sweep is clearing in the same cycle, the access wins and the reference bit stays 1.
- R11: `req` is ignored while `busy` is high. Each accepted request produces exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access to a frame this cycle |
| acc_frame | input | IW | Frame being accessed |
| acc_store | input | 1 | The access is a store |
| reload_valid | input | 1 | A frame has been reloaded |
| reload_frame | input | IW | Frame that was reloaded |
| req | input | 1 | Request a victim selection |
| prefer_clean | input | 1 | Use the clean-preferred search for this request |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Victim valid, one-cycle pulse |
| victim | output | IW | Chosen frame |
| victim_dirty | output | 1 | Dirty bit of the chosen frame |

## Verification
The bench checks that frames passed by the sweep lose their reference bit. A design that skipped the clearing would circle forever or pick a stale frame on a later sweep. It also covers the wrap from the last frame back to frame 0, the two-turn fallback when every frame is dirty, and the case of an access chasing the sweep. In that last case a design that let the clear win would return a different victim and a different latency on the next sweep. A second request sent while a sweep is running must not produce an extra `done`.

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NFRAMES = 8,
  localparam int IW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  input  logic          acc_store,
  input  logic          reload_valid,
  input  logic [IW-1:0] reload_frame,
  input  logic          req,
  input  logic          prefer_clean,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] victim,
  output logic          victim_dirty
);
  localparam int CW = $clog2(2 * NFRAMES) + 1;
  localparam logic [IW-1:0] LAST = IW'(NFRAMES - 1);
  localparam logic [CW-1:0] LIMIT = CW'(2 * NFRAMES - 1);

  logic [NFRAMES-1:0] ref_q, dirty_q;
  logic [IW-1:0] ptr_q, cur_q, fb_idx_q, victim_q;
  logic [CW-1:0] cnt_q;
  logic busy_q, clean_q, fb_v_q, done_q, vdirty_q;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  wire cur_ref   = ref_q[cur_q];
  wire cur_dirty = dirty_q[cur_q];
  wire hit_clean = !cur_ref && !cur_dirty;
  wire last_exam = (cnt_q == LIMIT);
  wire pick      = busy_q && (clean_q ? (hit_clean || last_exam) : !cur_ref);
  wire [IW-1:0] pick_idx = (clean_q && !hit_clean && fb_v_q) ? fb_idx_q : cur_q;
  wire scan_clr  = busy_q && cur_ref;

  for (genvar i = 0; i < NFRAMES; i++) begin : g_frame
    wire acc_hit = acc_valid && (acc_frame == IW'(i));
    wire rl_hit  = reload_valid && (reload_frame == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else begin
        if (acc_hit)                                ref_q[i] <= 1'b1;
        else if (rl_hit)                            ref_q[i] <= 1'b0;
        else if (scan_clr && cur_q == IW'(i))       ref_q[i] <= 1'b0;
        if (acc_hit && acc_store)                   dirty_q[i] <= 1'b1;
        else if (rl_hit)                            dirty_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      clean_q  <= 1'b0;
      ptr_q    <= LAST;
      cur_q    <= '0;
      cnt_q    <= '0;
      fb_v_q   <= 1'b0;
      fb_idx_q <= '0;
      done_q   <= 1'b0;
      victim_q <= '0;
      vdirty_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req) begin
          busy_q  <= 1'b1;
          clean_q <= prefer_clean;
          cur_q   <= nxt(ptr_q);
          cnt_q   <= '0;
          fb_v_q  <= 1'b0;
        end
      end else if (pick) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        victim_q <= pick_idx;
        vdirty_q <= dirty_q[pick_idx];
        ptr_q    <= pick_idx;
      end else begin
        cur_q <= nxt(cur_q);
        cnt_q <= cnt_q + 1'b1;
        if (!fb_v_q && !cur_ref) begin
          fb_v_q   <= 1'b1;
          fb_idx_q <= cur_q;
        end
      end
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign victim       = victim_q;
  assign victim_dirty = vdirty_q;
endmodule

module clock_victim_sel_chk #(
  parameter int NFRAMES = 8,
  localparam int IW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [IW-1:0]      acc_frame,
  input logic               acc_store,
  input logic               busy,
  input logic               done,
  input logic [IW-1:0]      victim,
  input logic [NFRAMES-1:0] ref_q,
  input logic [NFRAMES-1:0] dirty_q,
  input logic [IW-1:0]      ptr_q
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (ptr_q == IW'(NFRAMES - 1) && !busy && !done && ref_q == '0 && dirty_q == '0));
  a_r2_access_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ref_q[$past(acc_frame)]);
  a_r2_store_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_store) |=> dirty_q[$past(acc_frame)]);
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_ptr_on_victim: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ptr_q == victim);
  a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NFRAMES(NFRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
  .acc_store(acc_store), .busy(busy), .done(done), .victim(victim),
  .ref_q(ref_q), .dirty_q(dirty_q), .ptr_q(ptr_q)
);

// File: tb/clock_victim_sel_tb.sv
module clock_victim_sel_tb;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_store = 1'b0, reload_valid = 1'b0;
  logic req = 1'b0, prefer_clean = 1'b0;
  logic [IW-1:0] acc_frame = '0, reload_frame = '0;
  logic busy, done, victim_dirty;
  logic [IW-1:0] victim;

  always #2.5 clk = ~clk;

  clock_victim_sel #(.NFRAMES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .acc_store(acc_store), .reload_valid(reload_valid), .reload_frame(reload_frame),
    .req(req), .prefer_clean(prefer_clean), .busy(busy), .done(done),
    .victim(victim), .victim_dirty(victim_dirty)
  );

  int n_tests = 0, n_fail = 0;
  bit mref[N], mdirty[N];
  int mptr = N - 1;
  int qv[$];
  bit qd[$];
  string qtag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (qv.size() == 0) begin
        check(1'b0, "R11 unexpected done", 1, 0);
      end else begin
        int ev; bit ed; string t;
        ev = qv.pop_front(); ed = qd.pop_front(); t = qtag.pop_front();
        check(victim == IW'(ev), {t, " victim"}, victim, ev);
        check(victim_dirty == ed, {"R8 ", t, " victim_dirty"}, victim_dirty, ed);
      end
    end
  end

  task automatic access(input int f, input bit st);
    @(negedge clk);
    acc_valid = 1'b1; acc_frame = IW'(f); acc_store = st;
    @(negedge clk);
    acc_valid = 1'b0; acc_store = 1'b0;
    mref[f] = 1'b1;
    if (st) mdirty[f] = 1'b1;
  endtask

  task automatic reload(input int f);
    @(negedge clk);
    reload_valid = 1'b1; reload_frame = IW'(f);
    @(negedge clk);
    reload_valid = 1'b0;
    mref[f] = 1'b0; mdirty[f] = 1'b0;
  endtask

  function automatic void model_scan(input bit clean, output int v, output int k);
    int p, fb;
    p = (mptr + 1) % N; fb = -1; v = -1; k = 0;
    for (int step = 1; step <= 4 * N; step++) begin
      bit hit;
      if (clean) hit = (!mref[p] && !mdirty[p]) || step == 2 * N;
      else hit = !mref[p];
      if (hit) begin
        if (clean && (mref[p] || mdirty[p])) v = (fb >= 0) ? fb : p;
        else v = p;
        k = step;
        if (mref[p]) mref[p] = 1'b0;
        break;
      end
      if (!mref[p] && fb < 0) fb = p;
      mref[p] = 1'b0;
      p = (p + 1) % N;
    end
    mptr = v;
  endfunction

  task automatic do_req(input bit clean, input string tag);
    int v, k, c;
    model_scan(clean, v, k);
    qv.push_back(v); qd.push_back(mdirty[v]); qtag.push_back(tag);
    @(negedge clk);
    req = 1'b1; prefer_clean = clean;
    @(negedge clk);
    req = 1'b0;
    c = 1;
    while (!done && c < 200) begin
      @(negedge clk);
      c++;
    end
    check(c == k + 1, {"R4 ", tag, " latency"}, c, k + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R1 busy after reset", busy, 0);
    check(!done, "R1 done after reset", done, 0);
    do_req(1'b0, "R1 first victim frame 0");

    access(1, 0); access(2, 1);
    do_req(1'b0, "R5 skip referenced");
    for (int i = 0; i < 6; i++) do_req(1'b0, "R9 wrap around");

    access(2, 1); access(3, 1); access(4, 0);
    do_req(1'b1, "R6 clean preferred");

    for (int f = 0; f < N; f++) access(f, 1);
    do_req(1'b1, "R7 fallback all dirty");

    for (int f = 0; f < N; f++) access(f, 1);
    begin
      int start, c;
      start = (mptr + 1) % N;
      qv.push_back(mptr); qd.push_back(1'b1); qtag.push_back("R7 R10 chase");
      @(negedge clk);
      req = 1'b1; prefer_clean = 1'b1;
      c = 0;
      for (int i = 0; i < 2 * N; i++) begin
        @(negedge clk);
        c++;
        req = 1'b0;
        acc_valid = 1'b1; acc_frame = IW'((start + i) % N); acc_store = 1'b1;
      end
      @(negedge clk);
      c++;
      acc_valid = 1'b0; acc_store = 1'b0;
      check(done == 1'b1, "R7 chase done timing", done, 1);
      check(c == 2 * N + 1, "R7 chase cycles", c, 2 * N + 1);
    end
    do_req(1'b0, "R10 refs kept by access priority");

    for (int f = 0; f < N; f++) access(f, 1);
    reload((mptr + 3) % N);
    do_req(1'b0, "R3 reloaded frame clean");

    for (int f = 0; f < N; f++) access(f, 0);
    begin
      int v, k, c;
      model_scan(1'b0, v, k);
      qv.push_back(v); qd.push_back(mdirty[v]); qtag.push_back("R11 req while busy");
      @(negedge clk); req = 1'b1; prefer_clean = 1'b0;
      @(negedge clk); req = 1'b0;
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
      c = 3;
      while (!done && c < 200) begin @(negedge clk); c++; end
      check(c == k + 1, "R11 latency unchanged", c, k + 1);
      repeat (20) @(negedge clk);
      check(qv.size() == 0, "R11 one done per request", qv.size(), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule